// File: doc/BRIEF.md
# Two-Wire Bus Master Clock Generator with Multi-Master Synchronization

This block produces the clock line of a two-wire bus master and keeps it in step with any other masters on the same wired-AND clock net. It never drives the line high: it either pulls it low or lets go, and it watches the real bus level through a two-flop synchronizer. Each bus clock period is built from a programmed low time and a programmed high time, both counted in system clock cycles.

After its own low time has elapsed the block lets go of the line, then waits for as long as any other device keeps the line low. Its high-time count begins only once the line is seen high. If some other master pulls the line low before the high count is over, the block drops that count and starts its own low phase at once. The bus clock therefore has the longest low time and the shortest high time among all participating masters. Two one-cycle strobes go to a data shifter: one on every rising edge of the synchronized line, for sampling, and one when this master begins to pull low, for changing data.

Top module: `scl_clock_sync`

## Requirements
- R1: During and right after reset the line is released (`scl_drive_low` = 0) and neither strobe is asserted.
- R2: `scl_in` passes through two flops before any use. A change on `scl_in` therefore first acts on state or strobes at the third rising clock edge after the change.
- R3: Each low phase keeps `scl_drive_low` = 1 for exactly `low_count` consecutive cycles. A value of 0 counts as 1.
- R4: After a low phase the line is released. While the synchronized bus stays low the block waits, does not count, and does not drive.
- R5: The high count starts in the cycle after the synchronized bus is first seen high. After `high_count` counted cycles with the bus still high (0 counts as 1), a new low phase begins.
- R6: If the synchronized bus goes low during the high count, that count is dropped and `scl_drive_low` rises in the next cycle.
- R7: `shift_strobe` is high for exactly the first cycle of every low phase and at no other time.
- R8: `sample_strobe` is high for one cycle on each low-to-high transition of the synchronized bus level while `enable` = 1.
- R9: While `enable` = 0 the line is released, both counts are cleared and no strobes occur. On re-enable, a full low phase starts first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the clock generator when high |
| low_count | input | 8 | Low time in system cycles (0 treated as 1) |
| high_count | input | 8 | High time in system cycles (0 treated as 1) |
| scl_in | input | 1 | Raw level of the shared clock line |
| scl_drive_low | output | 1 | Open-drain pull-down enable for the clock line |
| sample_strobe | output | 1 | One-cycle pulse on each synchronized rising edge |
| shift_strobe | output | 1 | One-cycle pulse when this master starts pulling low |

## Verification
The hardest case to reach is another master pulling the line low while this block is partway through its high count. The block's own release reaches the counter only after the synchronizer delay, so the outside pull-down must land inside a narrow window. The bench models the bus as the AND of this block's output and a second pull-down that it controls. It uses long high counts and several pull-down pulses at different offsets, and it also holds the line low for long stretches to force the waiting state. A behavioural model with its own integer counters predicts every output on every cycle.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  // Period complete when the count just finished reaches the limit.
  // A limit of zero behaves like one.
  function automatic logic period_reached(input logic [7:0] cnt, input logic [7:0] limit);
    logic [8:0] next_cnt;
    next_cnt = {1'b0, cnt} + 9'd1;
    return next_cnt >= {1'b0, limit};
  endfunction

endpackage

// File: rtl/scl_input_sync.sv
module scl_input_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic synced,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= raw_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[gi] <= 1'b1;
          else        chain[gi] <= chain[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];

  assign synced = chain[STAGES-1];
  assign rise   = synced & ~prev;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R8
endmodule

// File: rtl/scl_period_counter.sv
module scl_period_counter
  import scl_sync_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;

  assign done = period_reached(cnt, limit);

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt == '0); // R9
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_sync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic bus_high,
  input  logic period_done,
  output logic cnt_clear,
  output logic cnt_run,
  output logic sel_high,
  output logic drive_low,
  output logic shift_strobe
);
  phase_e st, st_nxt;

  // named events for checking
  logic low_over, bus_seen_high, high_abandon, high_over;

  assign low_over      = (st == PH_LOW)  && period_done;
  assign bus_seen_high = (st == PH_WAIT) && bus_high;
  assign high_abandon  = (st == PH_HIGH) && !bus_high;
  assign high_over     = (st == PH_HIGH) && bus_high && period_done;

  always_comb begin
    st_nxt    = st;
    cnt_clear = 1'b0;
    cnt_run   = 1'b0;
    if (!enable) begin
      st_nxt    = PH_IDLE;
      cnt_clear = 1'b1;
    end else begin
      unique case (st)
        PH_IDLE: begin
          st_nxt    = PH_LOW;
          cnt_clear = 1'b1;
        end
        PH_LOW: begin
          if (low_over) begin
            st_nxt    = PH_WAIT;
            cnt_clear = 1'b1;
          end else cnt_run = 1'b1;
        end
        PH_WAIT: begin
          cnt_clear = 1'b1;
          if (bus_seen_high) st_nxt = PH_HIGH;
        end
        PH_HIGH: begin
          if (high_abandon || high_over) begin
            st_nxt    = PH_LOW;
            cnt_clear = 1'b1;
          end else cnt_run = 1'b1;
        end
        default: st_nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st           <= PH_IDLE;
      shift_strobe <= 1'b0;
    end else begin
      st           <= st_nxt;
      shift_strobe <= (st_nxt == PH_LOW) && (st != PH_LOW);
    end

  assign sel_high  = (st == PH_HIGH);
  assign drive_low = (st == PH_LOW);

  AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && drive_low && !period_done) |=> drive_low); // R3
  AST_WAIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && st == PH_WAIT && !bus_high) |=> (st == PH_WAIT && !drive_low)); // R4
  AST_ABANDON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && high_abandon) |=> (drive_low && shift_strobe)); // R6
  AST_SHIFT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_strobe |=> !shift_strobe); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!drive_low && !shift_strobe)); // R9
endmodule

// File: rtl/scl_clock_sync.sv
module scl_clock_sync
  import scl_sync_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] low_count,
  input  logic [CNT_W-1:0] high_count,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             sample_strobe,
  output logic             shift_strobe
);
  logic bus_high, bus_rise;
  logic cnt_clear, cnt_run, sel_high, period_done;
  logic [CNT_W-1:0] limit;

  scl_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(scl_in),
    .synced(bus_high), .rise(bus_rise)
  );

  assign limit = sel_high ? high_count : low_count;

  scl_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .run(cnt_run),
    .limit(limit), .done(period_done)
  );

  scl_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bus_high(bus_high),
    .period_done(period_done), .cnt_clear(cnt_clear), .cnt_run(cnt_run),
    .sel_high(sel_high), .drive_low(scl_drive_low), .shift_strobe(shift_strobe)
  );

  assign sample_strobe = enable & bus_rise;

  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> !sample_strobe); // R8
  AST_NO_DRIVE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(enable) |=> !scl_drive_low); // R9
endmodule

// File: tb/scl_clock_sync_bench.sv
`timescale 1ns/100ps
module scl_clock_sync_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] low_count = 8'd4;
  logic [7:0] high_count = 8'd3;
  logic       ext_low = 1'b0;
  logic       scl_in;
  logic       scl_drive_low, sample_strobe, shift_strobe;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  // wired-AND bus: either party pulling low wins
  assign scl_in = !(scl_drive_low || ext_low);

  scl_clock_sync u_scl_clock_sync (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .low_count(low_count), .high_count(high_count), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .sample_strobe(sample_strobe),
    .shift_strobe(shift_strobe)
  );

  // behavioural reference: 0 idle, 1 pulling low, 2 waiting, 3 counting high
  int m_phase, m_elapsed;
  bit m_q1, m_q2, m_q3, m_shift;

  function automatic int eff(input logic [7:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_elapsed = 0; m_shift = 0;
      m_q1 = 1; m_q2 = 1; m_q3 = 1;
    end else begin
      int old_phase;
      old_phase = m_phase;
      if (!enable) begin
        m_phase = 0; m_elapsed = 0;
      end else if (m_phase == 0) begin
        m_phase = 1; m_elapsed = 0;
      end else if (m_phase == 1) begin
        m_elapsed++;
        if (m_elapsed >= eff(low_count)) begin m_phase = 2; m_elapsed = 0; end
      end else if (m_phase == 2) begin
        if (m_q2) begin m_phase = 3; m_elapsed = 0; end
      end else begin
        m_elapsed++;
        if (!m_q2 || m_elapsed >= eff(high_count)) begin m_phase = 1; m_elapsed = 0; end
      end
      m_shift = (m_phase == 1) && (old_phase != 1);
      m_q3 = m_q2; m_q2 = m_q1; m_q1 = scl_in;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0b expected %0b", req, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R3/R4/R5/R6 drive", scl_drive_low, m_phase == 1);
    check("R7 shift_strobe", shift_strobe, m_shift);
    check("R2/R8 sample_strobe", sample_strobe, enable && m_q2 && !m_q3);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic hold_ext(input int n);
    ext_low = 1'b1;
    step(n);
    ext_low = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int run_len;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 drive in reset", scl_drive_low, 1'b0);
    check("R1 shift in reset", shift_strobe, 1'b0);
    check("R1 sample in reset", sample_strobe, 1'b0);
    rst_n = 1'b1;
    step(3);
    check("R1 drive after reset", scl_drive_low, 1'b0);

    // R3/R5/R7: free-running, single master
    enable = 1'b1;
    step(60);
    // R3: measure one low phase directly
    while (!shift_strobe) step(1);
    run_len = 0;
    while (scl_drive_low) begin run_len++; step(1); end
    tests++;
    if (run_len != 4) begin fails++; $display("FAIL R3 low length: actual %0d expected 4", run_len); end

    // R4: another device stretches the low time
    while (!scl_drive_low) step(1);
    hold_ext(25);
    step(10);

    // R6: other master cuts high phase short at many offsets
    high_count = 8'd30;
    for (int k = 0; k < 12; k++) begin
      while (!(scl_in && !scl_drive_low)) step(1);
      step(k);
      hold_ext(3 + k % 4);
      step(5);
    end
    step(40);

    // R3/R5: zero counts act as one
    low_count = 8'd0; high_count = 8'd0;
    step(40);
    low_count = 8'd255; high_count = 8'd1;
    step(600);

    // R9: disable mid-phase, stay idle, re-enable
    low_count = 8'd5; high_count = 8'd6;
    step(7);
    enable = 1'b0;
    step(1);
    check("R9 drive after disable", scl_drive_low, 1'b0);
    for (int i = 0; i < 20; i++) begin
      step(1);
      check("R9 quiet shift", shift_strobe, 1'b0);
      check("R9 quiet sample", sample_strobe, 1'b0);
    end
    enable = 1'b1;
    step(1);
    check("R9 restart drives low", scl_drive_low, 1'b1);
    run_len = 1;
    step(1);
    while (scl_drive_low) begin run_len++; step(1); end
    tests++;
    if (run_len != 5) begin fails++; $display("FAIL R9 restart low length: actual %0d expected 5", run_len); end
    step(80);
    summary();
  end
endmodule